// File: doc/BRIEF.md
# Integer and Single-Precision Float Conversion Unit

This block converts values in both directions between signed 32-bit integers and IEEE-754 binary32 numbers. It sits beside the floating-point side of a RISC core. A request carries a 6-bit sub-opcode that selects the direction, a 32-bit operand and a 2-bit rounding mode taken from the floating-point control register. Any sub-opcode the block does not implement is answered with an illegal-operation flag.

Each request is taken on a valid/ready handshake, and only one request is in flight at a time. The request is held in an operand stage, converted by combinational logic and registered into the response stage. The response is a one-cycle valid pulse that carries the 32-bit result. Float-to-integer results saturate when the value is NaN or lies outside the signed 32-bit range. The integer result fills the whole 32-bit register.

Top module: `fcvt_unit`

## Requirements
- R1: Sub-opcode 0x04 selects integer-to-float and sub-opcode 0x05 selects float-to-integer. Any other sub-opcode gives a response with `rsp_illegal` = 1 and `rsp_data` = 0. Legal operations respond with `rsp_illegal` = 0.
- R2: The rounding-mode encoding on `req_rm` is: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R3: Integer-to-float treats the operand as two's complement. Magnitudes below 2^24 convert exactly, zero gives 0x00000000 (+0.0), and -2^31 gives 0xCF000000.
- R4: Integer-to-float rounds a magnitude that needs more than 24 significant bits to 24 bits under the selected mode, using guard, round and sticky bits. A carry out of the rounding raises the exponent.
- R5: Float-to-integer rounds any fractional part under the selected mode. Denormals and values below one in magnitude round to 0 or to ±1.
- R6: Float-to-integer saturates to 0x7FFFFFFF for a positive value at or above 2^31 and for +infinity. It saturates to 0x80000000 for a value below -2^31 and for -infinity. Every NaN gives 0x7FFFFFFF.
- R7: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Its result is registered on the second rising edge, counting the accepting edge as the first. `rsp_valid` is then high for exactly one cycle.
- R8: `req_ready` is 0 from the accepting edge until the edge that ends the response cycle. A request held on the port in that interval is not taken. It is accepted once `req_ready` returns to 1.
- R9: While a synchronous reset is applied and after it is released, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The unit can accept a request |
| req_op | input | 6 | Sub-opcode |
| req_data | input | 32 | Operand: an integer or a binary32 value |
| req_rm | input | 2 | Rounding mode |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | 32 | Result |
| rsp_illegal | output | 1 | The sub-opcode was not recognised |

## Verification
The response for one request and the arrival of the next request can fall in the same cycle. The bench provokes this by holding a second request with `req_valid` high through the whole life of the first. It checks that `req_ready` stays low while the first result is pulsed out, so the second operand cannot disturb the first result. It then checks that the second request is accepted only after the response cycle and returns its own result with the normal latency.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int OP_W   = 6;
  localparam int INT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int SIG_W  = MAN_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int LZ_W   = $clog2(INT_W);
  // exponent of an integer whose top bit is set
  localparam int TOP_EXP = BIAS + INT_W - 1;

  localparam logic [OP_W-1:0] OP_I2F = 6'h04;
  localparam logic [OP_W-1:0] OP_F2I = 6'h05;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_ZERO      = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rmode_e;
endpackage

// File: rtl/fcvt_rnd_dec.sv
// Decides whether the truncated magnitude must be incremented.
module fcvt_rnd_dec
  import fcvt_pkg::*;
(
  input  rmode_e rm,
  input  logic   neg,
  input  logic   lsb,
  input  logic   guard,
  input  logic   sticky,
  output logic   inc
);
  always_comb begin
    unique case (rm)
      RM_NEAR_EVEN: inc = guard & (lsb | sticky);
      RM_ZERO:      inc = 1'b0;
      RM_UP:        inc = ~neg & (guard | sticky);
      RM_DOWN:      inc = neg & (guard | sticky);
      default:      inc = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcvt_i2f.sv
// Signed integer to binary32, combinational.
module fcvt_i2f
  import fcvt_pkg::*;
(
  input  logic [INT_W-1:0] a,
  input  rmode_e           rm,
  output logic [31:0]      f
);
  localparam int DROP = INT_W - SIG_W;   // bits below the significand

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] norm;
  logic [LZ_W-1:0]  lz;
  logic             found;
  logic             inc;
  logic [SIG_W:0]   sum;
  logic [EXP_W-1:0] exp_b;
  logic [MAN_W-1:0] man;

  assign neg = a[INT_W-1];
  assign mag = neg ? (~a + 1'b1) : a;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = INT_W - 1; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lz    = LZ_W'(INT_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign norm = mag << lz;

  fcvt_rnd_dec u_rnd (
    .rm     (rm),
    .neg    (neg),
    .lsb    (norm[DROP]),
    .guard  (norm[DROP-1]),
    .sticky (|norm[DROP-2:0]),
    .inc    (inc)
  );

  assign sum = {1'b0, norm[INT_W-1:DROP]} + {{SIG_W{1'b0}}, inc};

  always_comb begin
    exp_b = EXP_W'(TOP_EXP) - EXP_W'(lz);
    if (sum[SIG_W]) begin
      exp_b = exp_b + 1'b1;
      man   = sum[SIG_W-1:1];
    end else begin
      man   = sum[MAN_W-1:0];
    end
    if (!found) f = '0;
    else        f = {neg, exp_b, man};
  end
endmodule

// File: rtl/fcvt_f2i.sv
// Binary32 to signed integer with saturation, combinational.
module fcvt_f2i
  import fcvt_pkg::*;
(
  input  logic [31:0]      f,
  input  rmode_e           rm,
  output logic [INT_W-1:0] r
);
  localparam int QW      = 2 * INT_W;
  localparam int HALF_E  = BIAS - 1;                 // exponent of 0.5
  localparam int SAT_E   = BIAS + INT_W - 1;         // exponent of 2^31
  localparam int SH_BASE = BIAS + MAN_W - INT_W;     // shift offset

  logic             neg;
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic [SIG_W-1:0] sig;
  logic             is_nan, is_big;
  logic [EXP_W-1:0] sh;
  logic [QW-1:0]    q;
  logic [INT_W-1:0] ipart;
  logic             g, st, inc;
  logic [INT_W:0]   mag;

  assign neg = f[31];
  assign e   = f[30:23];
  assign m   = f[22:0];
  assign sig = {(e != '0), m};
  assign is_nan = (e == '1) && (m != '0);
  assign is_big = (e >= EXP_W'(SAT_E));

  always_comb begin
    sh = e - EXP_W'(SH_BASE);
    q  = '0;
    if (e >= EXP_W'(HALF_E)) begin
      q     = {{(QW-SIG_W){1'b0}}, sig} << sh[5:0];
      ipart = q[QW-1:INT_W];
      g     = q[INT_W-1];
      st    = |q[INT_W-2:0];
    end else begin
      ipart = '0;
      g     = 1'b0;
      st    = (e != '0) || (m != '0);
    end
  end

  fcvt_rnd_dec u_rnd (
    .rm     (rm),
    .neg    (neg),
    .lsb    (ipart[0]),
    .guard  (g),
    .sticky (st),
    .inc    (inc)
  );

  assign mag = {1'b0, ipart} + {{INT_W{1'b0}}, inc};

  always_comb begin
    if (is_nan)
      r = {1'b0, {(INT_W-1){1'b1}}};
    else if (is_big)
      r = neg ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    else if (!neg)
      r = (mag > {2'b00, {(INT_W-1){1'b1}}}) ? {1'b0, {(INT_W-1){1'b1}}}
                                            : mag[INT_W-1:0];
    else
      r = (mag > {2'b01, {(INT_W-1){1'b0}}}) ? {1'b1, {(INT_W-1){1'b0}}}
                                            : (~mag[INT_W-1:0] + 1'b1);
  end
endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OP_W-1:0]  req_op,
  input  logic [INT_W-1:0] req_data,
  input  logic [1:0]       req_rm,
  output logic             rsp_valid,
  output logic [INT_W-1:0] rsp_data,
  output logic             rsp_illegal
);
  logic             s1_v;
  logic [OP_W-1:0]  s1_op;
  logic [INT_W-1:0] s1_data;
  rmode_e           s1_rm;
  logic [31:0]      i2f_res;
  logic [INT_W-1:0] f2i_res;
  logic             accept;

  assign req_ready = ~s1_v & ~rsp_valid;
  assign accept    = req_valid & req_ready;

  // operand stage
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_op   <= '0;
      s1_data <= '0;
      s1_rm   <= RM_NEAR_EVEN;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_op   <= req_op;
        s1_data <= req_data;
        s1_rm   <= rmode_e'(req_rm);
      end
    end
  end

  fcvt_i2f u_i2f (.a(s1_data), .rm(s1_rm), .f(i2f_res));
  fcvt_f2i u_f2i (.f(s1_data), .rm(s1_rm), .r(f2i_res));

  // response stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid <= s1_v;
      if (s1_v) begin
        unique case (s1_op)
          OP_I2F: begin rsp_data <= i2f_res; rsp_illegal <= 1'b0; end
          OP_F2I: begin rsp_data <= f2i_res; rsp_illegal <= 1'b0; end
          default: begin rsp_data <= '0; rsp_illegal <= 1'b1; end
        endcase
      end
    end
  end
endmodule

// File: rtl/fcvt_unit_chk.sv
module fcvt_unit_chk
  import fcvt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OP_W-1:0]  req_op,
  input logic [INT_W-1:0] req_data,
  input logic             rsp_valid,
  input logic [INT_W-1:0] rsp_data,
  input logic             rsp_illegal
);
  logic acc;
  assign acc = req_valid & req_ready;

  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##2 rsp_valid);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> !req_ready);

  a_r8_busy_during_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r1_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_illegal) |-> (rsp_data == '0));

  a_r3_zero_pos: assert property (@(posedge clk) disable iff (rst)
    ($past(acc, 2) && $past(req_op, 2) == OP_I2F && $past(req_data, 2) == '0)
      |-> (rsp_valid && !rsp_illegal && rsp_data == '0));
endmodule

bind fcvt_unit fcvt_unit_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .req_data   (req_data),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .rsp_illegal(rsp_illegal)
);

// File: tb/test_fcvt_unit.sv
`timescale 1ns/1ps
module test_fcvt_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [5:0]  req_op;
  logic [31:0] req_data;
  logic [1:0]  req_rm;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  fcvt_unit i_fcvt_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .req_rm(req_rm),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // One full transaction, checked cycle by cycle.
  task automatic xact(input string req, input logic [5:0] op, input logic [31:0] d,
                      input logic [1:0] rm, input logic [31:0] exp, input logic ill);
    @(negedge clk);
    chk({req, " R8 ready before"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_op = op; req_data = d; req_rm = rm;
    @(negedge clk);                       // accepted at the edge just passed
    req_valid = 1'b0; req_data = 32'hDEAD_BEEF;
    chk({req, " R7 no early rsp"}, 32'(rsp_valid), 32'd0);
    chk({req, " R8 busy"}, 32'(req_ready), 32'd0);
    @(negedge clk);
    chk({req, " R7 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " data"}, rsp_data, exp);
    chk({req, " R1 illegal flag"}, 32'(rsp_illegal), 32'(ill));
    @(negedge clk);
    chk({req, " R7 pulse ends"}, 32'(rsp_valid), 32'd0);
    chk({req, " R8 ready again"}, 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_data = '0; req_rm = '0;
    repeat (3) @(negedge clk);
    chk("R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R9 ready in reset", 32'(req_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R9 ready after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic t_i2f_exact();
    xact("R3 zero",     6'h04, 32'd0,         2'd0, 32'h0000_0000, 1'b0);
    xact("R3 one",      6'h04, 32'd1,         2'd0, 32'h3F80_0000, 1'b0);
    xact("R3 minus one",6'h04, 32'hFFFF_FFFF, 2'd0, 32'hBF80_0000, 1'b0);
    xact("R3 int min",  6'h04, 32'h8000_0000, 2'd1, 32'hCF00_0000, 1'b0);
  endtask

  task automatic t_i2f_round();
    xact("R4 R2 tie even rne", 6'h04, 32'h0100_0001, 2'd0, 32'h4B80_0000, 1'b0);
    xact("R4 R2 tie odd rne",  6'h04, 32'h0100_0003, 2'd0, 32'h4B80_0002, 1'b0);
    xact("R4 R2 tie rtz",      6'h04, 32'h0100_0001, 2'd1, 32'h4B80_0000, 1'b0);
    xact("R4 R2 tie rup",      6'h04, 32'h0100_0001, 2'd2, 32'h4B80_0001, 1'b0);
    xact("R4 R2 tie rdn pos",  6'h04, 32'h0100_0001, 2'd3, 32'h4B80_0000, 1'b0);
    xact("R4 R2 neg rdn",      6'h04, -32'sd16777217, 2'd3, 32'hCB80_0001, 1'b0);
    xact("R4 R2 neg rup",      6'h04, -32'sd16777217, 2'd2, 32'hCB80_0000, 1'b0);
    xact("R4 carry exp rne",   6'h04, 32'h7FFF_FFFF, 2'd0, 32'h4F00_0000, 1'b0);
    xact("R4 max rtz",         6'h04, 32'h7FFF_FFFF, 2'd1, 32'h4EFF_FFFF, 1'b0);
  endtask

  task automatic t_f2i_round();
    xact("R5 R2 1.5 rne",  6'h05, 32'h3FC0_0000, 2'd0, 32'd2, 1'b0);
    xact("R5 R2 1.5 rtz",  6'h05, 32'h3FC0_0000, 2'd1, 32'd1, 1'b0);
    xact("R5 R2 1.5 rup",  6'h05, 32'h3FC0_0000, 2'd2, 32'd2, 1'b0);
    xact("R5 R2 1.5 rdn",  6'h05, 32'h3FC0_0000, 2'd3, 32'd1, 1'b0);
    xact("R5 2.5 rne",     6'h05, 32'h4020_0000, 2'd0, 32'd2, 1'b0);
    xact("R5 -1.5 rne",    6'h05, 32'hBFC0_0000, 2'd0, 32'hFFFF_FFFE, 1'b0);
    xact("R5 -1.5 rtz",    6'h05, 32'hBFC0_0000, 2'd1, 32'hFFFF_FFFF, 1'b0);
    xact("R5 -1.5 rup",    6'h05, 32'hBFC0_0000, 2'd2, 32'hFFFF_FFFF, 1'b0);
    xact("R5 -1.5 rdn",    6'h05, 32'hBFC0_0000, 2'd3, 32'hFFFF_FFFE, 1'b0);
    xact("R5 0.5 rne",     6'h05, 32'h3F00_0000, 2'd0, 32'd0, 1'b0);
    xact("R5 0.5 rup",     6'h05, 32'h3F00_0000, 2'd2, 32'd1, 1'b0);
    xact("R5 0.25 rup",    6'h05, 32'h3E80_0000, 2'd2, 32'd1, 1'b0);
    xact("R5 -0.25 rdn",   6'h05, 32'hBE80_0000, 2'd3, 32'hFFFF_FFFF, 1'b0);
    xact("R5 denorm rne",  6'h05, 32'h0000_0001, 2'd0, 32'd0, 1'b0);
    xact("R5 denorm rup",  6'h05, 32'h0000_0001, 2'd2, 32'd1, 1'b0);
    xact("R5 large exact", 6'h05, 32'h4EFF_FFFF, 2'd0, 32'h7FFF_FF80, 1'b0);
  endtask

  task automatic t_f2i_sat();
    xact("R6 2^31",   6'h05, 32'h4F00_0000, 2'd0, 32'h7FFF_FFFF, 1'b0);
    xact("R6 -2^31",  6'h05, 32'hCF00_0000, 2'd0, 32'h8000_0000, 1'b0);
    xact("R6 -2^32",  6'h05, 32'hCF80_0000, 2'd1, 32'h8000_0000, 1'b0);
    xact("R6 +inf",   6'h05, 32'h7F80_0000, 2'd0, 32'h7FFF_FFFF, 1'b0);
    xact("R6 -inf",   6'h05, 32'hFF80_0000, 2'd0, 32'h8000_0000, 1'b0);
    xact("R6 neg nan",6'h05, 32'hFFC0_0000, 2'd3, 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_illegal();
    xact("R1 op 0x00", 6'h00, 32'h3F80_0000, 2'd0, 32'h0, 1'b1);
    xact("R1 op 0x06", 6'h06, 32'h0000_0001, 2'd0, 32'h0, 1'b1);
    xact("R1 op 0x3F", 6'h3F, 32'hFFFF_FFFF, 2'd2, 32'h0, 1'b1);
  endtask

  // Second request held on the port while the first is answered.
  task automatic t_overlap();
    @(negedge clk);
    req_valid = 1'b1; req_op = 6'h04; req_data = 32'd3; req_rm = 2'd0;
    @(negedge clk);                       // A accepted
    req_op = 6'h05; req_data = 32'h4040_0000; req_rm = 2'd0;   // B = 3.0
    chk("R8 held req blocked", 32'(req_ready), 32'd0);
    chk("R7 overlap no early rsp", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R8 ready low in rsp cycle", 32'(req_ready), 32'd0);
    chk("R7 overlap A valid", 32'(rsp_valid), 32'd1);
    chk("R3 overlap A data", rsp_data, 32'h4040_0000);
    @(negedge clk);
    chk("R8 ready after rsp", 32'(req_ready), 32'd1);
    chk("R7 overlap gap", 32'(rsp_valid), 32'd0);
    @(negedge clk);                       // B accepted
    req_valid = 1'b0;
    chk("R7 B no early rsp", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R7 B valid", 32'(rsp_valid), 32'd1);
    chk("R5 B data", rsp_data, 32'd3);
    @(negedge clk);
    chk("R7 B pulse ends", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    t_reset();
    t_i2f_exact();
    t_i2f_round();
    t_f2i_round();
    t_f2i_sat();
    t_illegal();
    t_overlap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule